// File: doc/BRIEF.md
# Phase-Line Command and Status Port for a 3.5-inch Drive

This block reuses the four stepper phase lines of a floppy controller, plus one extra select line, as a small command and status bus for a 3.5-inch drive. A mode input picks the meaning of the phases. When it is high, three phases and the select line form a 4-bit code. A rising edge on phase 3 executes that code as a command: set the step direction, step the head, choose the side, run or stop the drive's own spindle motor, or eject. The same code also picks one drive status bit, which is returned while the controller's Q7/Q6 pair is set to status-read.

Two phase combinations have a fixed meaning. Phases 0 and 2 together act as a controller reset. Phases 1 and 3 together raise the enable signal for the serial device bus. When the mode input is low, none of this applies and the phases drive a plain 5.25-inch half-track arm. The head position for the 3.5-inch drive is reported as track times two plus side.

Top module: `drv35_cmd_port`

## Requirements
- R1: With `mode35` low, commands, the reset combination and bus enable are all inert and `head_pos` never changes. With `mode35` high, the 5.25-inch arm position `arm_pos` never changes.
- R2: The code is `{sel, phase[2], phase[1], phase[0]}` (bit 3 down to bit 0). Command values: 0 direction inward, 1 direction outward, 2 step, 3 motor on, 4 motor off, 6 eject, 8 side 0, 9 side 1.
- R3: A command executes exactly once, on the clock edge where `phase[3]` is first seen high; holding `phase[3]` high does not repeat it.
- R4: A step moves the track by +1 when the direction flag is 1 and by -1 when it is 0, saturating at track 0 and track TRACKS-1 (79).
- R5: `head_pos` equals track*2 + side; side is set by commands 8 and 9.
- R6: Motor on sets `motor35`; the at-speed status rises SPINUP_CYC clock edges after the executing edge; a motor-on while already running does not restart that delay; motor off clears both.
- R7: The step-complete status reads 0 for STEP_CYC clock edges after a step command executes (including a saturated step) and 1 otherwise.
- R8: Command 6 sets the ejected flag; a high `media_insert` clears it on the next edge.
- R9: With `mode35`=1, `q7`=0 and `q6`=1, `status_bit` returns the bit picked by the code: 0 direction, 1 step complete, 2 motor running, 3 at speed, 4 track is 0, 6 ejected, 8 side, 9 disk present (not ejected), every other code 0. Any other `q7`/`q6`/`mode35` gives 0.
- R10: `phase[0]` and `phase[2]` both high in 3.5-inch mode drive `ctl_reset` high. They clear the motor, the direction flag and the ejected flag on the next edge, and no command executes on that edge.
- R11: `enable2` is high exactly when `mode35`, `phase[1]` and `phase[3]` are all high.
- R12: In 5.25-inch mode, when exactly one phase is on and it is phase (arm_pos+1) mod 4, the arm moves up by one, up to ARM_STEPS-1. When it is phase (arm_pos-1) mod 4, the arm moves down by one, down to 0. Otherwise the arm holds.
- R13: Codes with no assigned command (10, 11, 12, 14) change no state when executed.
- R14: After reset: track 0, side 0, direction 0, motor off, not ejected, step complete, `arm_pos` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode35 | input | 1 | 1: command/status use of phases, 0: 5.25-inch arm stepping |
| sel | input | 1 | Extra select line, code bit 3 |
| phase | input | 4 | Stepper phase line levels |
| q6 | input | 1 | Controller Q6 state |
| q7 | input | 1 | Controller Q7 state |
| media_insert | input | 1 | Clears the ejected flag |
| status_bit | output | 1 | Selected drive status bit |
| head_pos | output | $clog2(TRACKS)+1 | Track*2 + side |
| motor35 | output | 1 | 3.5-inch spindle motor running |
| arm_pos | output | $clog2(ARM_STEPS) | 5.25-inch arm position in half-tracks |
| ctl_reset | output | 1 | Controller reset combination present |
| enable2 | output | 1 | Serial device bus enable |

## Verification
The bench walks the track from 0 past 79 and back below 0. A design that wraps or drops the saturation would show a jump in `head_pos`. It sweeps all sixteen status codes in two different drive states, so a swapped index or a leaked unused code gives a wrong bit. It counts the settle delays edge by edge; an off-by-one counter shows up as status rising a cycle early or late. It holds phase 3 high and checks that only one step happens, which catches a level-triggered command latch. It walks the 5.25-inch arm past both ends, presents non-adjacent and paired phases to it, and runs a command in that mode, which would show arm wrap, spurious motion, or commands leaking across modes.

// File: rtl/drv35_pkg.sv
// Package: shared code values for the 3.5-inch phase-line command port.
// Assumes the code is {sel, phase[2], phase[1], phase[0]}.
package drv35_pkg;

    // Command values executed on the rising edge of phase 3.
    // Codes with phase 0 and phase 2 both set are never commands
    // because that combination is the controller reset.
    typedef enum logic [3:0] {
        CMD_DIR_IN    = 4'h0,
        CMD_DIR_OUT   = 4'h1,
        CMD_STEP      = 4'h2,
        CMD_MOTOR_ON  = 4'h3,
        CMD_MOTOR_OFF = 4'h4,
        CMD_EJECT     = 4'h6,
        CMD_SIDE0     = 4'h8,
        CMD_SIDE1     = 4'h9
    } drv35_cmd_e;

    // Status bit index selected by the same code.
    typedef enum logic [3:0] {
        ST_DIR       = 4'h0,
        ST_STEP_DONE = 4'h1,
        ST_MOTOR     = 4'h2,
        ST_AT_SPEED  = 4'h3,
        ST_TRACK0    = 4'h4,
        ST_EJECTED   = 4'h6,
        ST_SIDE      = 4'h8,
        ST_PRESENT   = 4'h9
    } drv35_stat_e;

endpackage

// File: rtl/drv35_phase_decode.sv
// Module: drv35_phase_decode
// Turns phase lines and the select line into a code, a one-cycle command
// strobe on the phase-3 rising edge, and the reset and bus-enable combos.
// Assumes phase inputs are already synchronous to clk.
module drv35_phase_decode (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode35,
    input  logic       sel,
    input  logic [3:0] phase,
    output logic [3:0] code,
    output logic       cmd_fire,
    output logic       ctl_reset,
    output logic       enable2
);

    logic ph3_q;

    // Remember last phase-3 level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ph3_q <= 1'b0;
        else        ph3_q <= phase[3];
    end

    assign code      = {sel, phase[2], phase[1], phase[0]};
    assign ctl_reset = mode35 & phase[0] & phase[2];
    assign enable2   = mode35 & phase[1] & phase[3];
    assign cmd_fire  = mode35 & phase[3] & ~ph3_q & ~ctl_reset;

    // A command strobe never lasts two cycles.
    assert_single_fire_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_fire |=> !cmd_fire);

endmodule

// File: rtl/drv35_head_ctl.sv
// Module: drv35_head_ctl
// Holds track, side and step direction, and times the step-complete status.
// Assumes TRACKS >= 2 and STEP_CYC >= 1.
module drv35_head_ctl
    import drv35_pkg::*;
#(
    parameter int TRACKS   = 80,
    parameter int STEP_CYC = 8,
    localparam int TW      = $clog2(TRACKS),
    localparam int SW      = $clog2(STEP_CYC + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_fire,
    input  logic [3:0]    code,
    input  logic          ctl_reset,
    output logic [TW-1:0] track,
    output logic          side,
    output logic          dir,
    output logic          step_done
);

    localparam logic [TW-1:0] TMAX = TW'(TRACKS - 1);

    logic [SW-1:0] busy_cnt;

    // Apply head commands; reset combination clears direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            track <= '0;
            side  <= 1'b0;
            dir   <= 1'b0;
        end else if (ctl_reset) begin
            dir <= 1'b0;
        end else if (cmd_fire) begin
            case (code)
                CMD_DIR_IN:  dir <= 1'b1;
                CMD_DIR_OUT: dir <= 1'b0;
                CMD_STEP: begin
                    if (dir) begin
                        if (track != TMAX) track <= track + 1'b1;
                    end else if (track != '0) begin
                        track <= track - 1'b1;
                    end
                end
                CMD_SIDE0:   side <= 1'b0;
                CMD_SIDE1:   side <= 1'b1;
                default:     ;
            endcase
        end
    end

    // Step settle timer, reloaded by every step command.
    always_ff @(posedge clk) begin
        if (!rst_n)                            busy_cnt <= '0;
        else if (cmd_fire && code == CMD_STEP) busy_cnt <= SW'(STEP_CYC);
        else if (busy_cnt != '0)               busy_cnt <= busy_cnt - 1'b1;
    end

    assign step_done = (busy_cnt == '0);

    assert_track_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        track <= TMAX);
    assert_floor_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_fire && code == CMD_STEP && !dir && track == '0) |=> track == '0);
    assert_step_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_fire && code == CMD_STEP) |=> !step_done);

endmodule

// File: rtl/drv35_motor_ctl.sv
// Module: drv35_motor_ctl
// Runs the drive's own spindle motor flag and its spin-up timer.
// Assumes SPINUP_CYC >= 1.
module drv35_motor_ctl
    import drv35_pkg::*;
#(
    parameter int SPINUP_CYC = 16,
    localparam int SW        = $clog2(SPINUP_CYC + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_fire,
    input  logic [3:0] code,
    input  logic       ctl_reset,
    output logic       motor_on,
    output logic       at_speed
);

    logic [SW-1:0] spin_cnt;

    // Motor on/off commands and spin-up countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            motor_on <= 1'b0;
            spin_cnt <= '0;
        end else if (ctl_reset) begin
            motor_on <= 1'b0;
            spin_cnt <= '0;
        end else if (cmd_fire && code == CMD_MOTOR_ON && !motor_on) begin
            motor_on <= 1'b1;
            spin_cnt <= SW'(SPINUP_CYC);
        end else if (cmd_fire && code == CMD_MOTOR_OFF) begin
            motor_on <= 1'b0;
            spin_cnt <= '0;
        end else if (spin_cnt != '0) begin
            spin_cnt <= spin_cnt - 1'b1;
        end
    end

    assign at_speed = motor_on && (spin_cnt == '0);

    assert_motor_cleared_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_reset |=> !motor_on);
    assert_spinup_delay_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_fire && code == CMD_MOTOR_ON && !motor_on && !ctl_reset) |=> !at_speed);

endmodule

// File: rtl/drv35_arm525.sv
// Module: drv35_arm525
// Half-track arm model for 5.25-inch mode: one energised phase adjacent
// to the current position pulls the arm one half-track toward it.
// Assumes ARM_STEPS >= 2.
module drv35_arm525 #(
    parameter int ARM_STEPS = 69,
    localparam int AW       = $clog2(ARM_STEPS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic [3:0]    phase,
    output logic [AW-1:0] arm_pos
);

    localparam logic [AW-1:0] AMAX = AW'(ARM_STEPS - 1);

    logic [1:0] fwd_ph;
    logic [1:0] back_ph;
    logic       single;

    assign fwd_ph  = arm_pos[1:0] + 2'd1;
    assign back_ph = arm_pos[1:0] - 2'd1;
    assign single  = (phase != 4'h0) && ((phase & (phase - 4'h1)) == 4'h0);

    // Move the arm toward a lone adjacent phase, clamped at both ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm_pos <= '0;
        end else if (active && single) begin
            if (phase[fwd_ph] && arm_pos != AMAX)       arm_pos <= arm_pos + 1'b1;
            else if (phase[back_ph] && arm_pos != '0)   arm_pos <= arm_pos - 1'b1;
        end
    end

    assert_one_halftrack_R12: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (arm_pos == $past(arm_pos)) || (arm_pos == $past(arm_pos) + 1'b1)
                 || (arm_pos + 1'b1 == $past(arm_pos)));
    assert_arm_range_R12: assert property (@(posedge clk) disable iff (!rst_n)
        arm_pos <= AMAX);

endmodule

// File: rtl/drv35_cmd_port.sv
// Module: drv35_cmd_port (top)
// Phase-line command and status port for a 3.5-inch drive, falling back
// to plain 5.25-inch arm stepping when mode35 is low.
// Assumes all inputs synchronous to clk; reset is synchronous, active low.
module drv35_cmd_port
    import drv35_pkg::*;
#(
    parameter int TRACKS     = 80,
    parameter int STEP_CYC   = 8,
    parameter int SPINUP_CYC = 16,
    parameter int ARM_STEPS  = 69
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         mode35,
    input  logic                         sel,
    input  logic [3:0]                   phase,
    input  logic                         q6,
    input  logic                         q7,
    input  logic                         media_insert,
    output logic                         status_bit,
    output logic [$clog2(TRACKS):0]      head_pos,
    output logic                         motor35,
    output logic [$clog2(ARM_STEPS)-1:0] arm_pos,
    output logic                         ctl_reset,
    output logic                         enable2
);

    localparam int TW = $clog2(TRACKS);

    logic [3:0]    code;
    logic          cmd_fire;
    logic [TW-1:0] track;
    logic          side;
    logic          dir;
    logic          step_done;
    logic          at_speed;
    logic          ejected;
    logic          sel_stat;

    drv35_phase_decode u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode35    (mode35),
        .sel       (sel),
        .phase     (phase),
        .code      (code),
        .cmd_fire  (cmd_fire),
        .ctl_reset (ctl_reset),
        .enable2   (enable2)
    );

    drv35_head_ctl #(
        .TRACKS   (TRACKS),
        .STEP_CYC (STEP_CYC)
    ) u_head (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_fire  (cmd_fire),
        .code      (code),
        .ctl_reset (ctl_reset),
        .track     (track),
        .side      (side),
        .dir       (dir),
        .step_done (step_done)
    );

    drv35_motor_ctl #(
        .SPINUP_CYC (SPINUP_CYC)
    ) u_motor (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_fire  (cmd_fire),
        .code      (code),
        .ctl_reset (ctl_reset),
        .motor_on  (motor35),
        .at_speed  (at_speed)
    );

    drv35_arm525 #(
        .ARM_STEPS (ARM_STEPS)
    ) u_arm (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (!mode35),
        .phase   (phase),
        .arm_pos (arm_pos)
    );

    // Ejected flag: set by command, cleared by insertion or reset combination.
    always_ff @(posedge clk) begin
        if (!rst_n)                             ejected <= 1'b0;
        else if (ctl_reset)                     ejected <= 1'b0;
        else if (cmd_fire && code == CMD_EJECT) ejected <= 1'b1;
        else if (media_insert)                  ejected <= 1'b0;
    end

    // Pick the status bit addressed by the current code.
    always_comb begin
        case (code)
            ST_DIR:       sel_stat = dir;
            ST_STEP_DONE: sel_stat = step_done;
            ST_MOTOR:     sel_stat = motor35;
            ST_AT_SPEED:  sel_stat = at_speed;
            ST_TRACK0:    sel_stat = (track == '0);
            ST_EJECTED:   sel_stat = ejected;
            ST_SIDE:      sel_stat = side;
            ST_PRESENT:   sel_stat = !ejected;
            default:      sel_stat = 1'b0;
        endcase
    end

    assign status_bit = mode35 & q6 & ~q7 & sel_stat;
    assign head_pos   = {track, side};

    assert_arm_frozen_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mode35 |=> $stable(arm_pos));
    assert_head_frozen_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !mode35 |=> $stable(head_pos));
    assert_eject_cleared_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_reset |=> status_bit == 1'b0 || code != ST_EJECTED);

endmodule

// File: tb/drv35_cmd_port_tb.sv
module drv35_cmd_port_tb;

    localparam int TRACKS     = 80;
    localparam int STEP_CYC   = 4;
    localparam int SPINUP_CYC = 6;
    localparam int ARM_STEPS  = 69;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       mode35;
    logic       sel;
    logic [3:0] phase;
    logic       q6;
    logic       q7;
    logic       media_insert;
    logic       status_bit;
    logic [7:0] head_pos;
    logic       motor35;
    logic [6:0] arm_pos;
    logic       ctl_reset;
    logic       enable2;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Bench model of the drive state.
    int m_track = 0;
    int m_side  = 0;
    int m_dir   = 0;
    int m_motor = 0;
    int m_eject = 0;
    int m_arm   = 0;

    always #10 clk = ~clk;

    drv35_cmd_port #(
        .TRACKS     (TRACKS),
        .STEP_CYC   (STEP_CYC),
        .SPINUP_CYC (SPINUP_CYC),
        .ARM_STEPS  (ARM_STEPS)
    ) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode35       (mode35),
        .sel          (sel),
        .phase        (phase),
        .q6           (q6),
        .q7           (q7),
        .media_insert (media_insert),
        .status_bit   (status_bit),
        .head_pos     (head_pos),
        .motor35      (motor35),
        .arm_pos      (arm_pos),
        .ctl_reset    (ctl_reset),
        .enable2      (enable2)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Present a status read for code c now; caller advances the clock.
    task automatic read_stat(input int c, output int v);
        phase = {1'b0, 3'(c)};
        sel   = c[3];
        q6    = 1'b1;
        q7    = 1'b0;
        #1;
        v = status_bit;
    endtask

    function automatic int exp_stat(input int c);
        case (c)
            0:       return m_dir;
            1:       return 1;
            2:       return m_motor;
            3:       return m_motor;
            4:       return (m_track == 0) ? 1 : 0;
            6:       return m_eject;
            8:       return m_side;
            9:       return m_eject ? 0 : 1;
            default: return 0;
        endcase
    endfunction

    function automatic void apply_cmd(input int c);
        case (c)
            0: m_dir = 1;
            1: m_dir = 0;
            2: begin
                if (m_dir == 1 && m_track < TRACKS - 1) m_track++;
                else if (m_dir == 0 && m_track > 0)     m_track--;
            end
            3: m_motor = 1;
            4: m_motor = 0;
            6: m_eject = 1;
            8: m_side = 0;
            9: m_side = 1;
            default: ;
        endcase
    endfunction

    // Issue code c through a phase-3 rising edge; returns one edge after it executes.
    task automatic issue(input int c);
        @(negedge clk);
        phase = {1'b0, 3'(c)};
        sel   = c[3];
        q6    = 1'b0;
        q7    = 1'b0;
        @(negedge clk);
        phase[3] = 1'b1;
        #1;
        check("R11 enable2 during command", enable2, (mode35 && c[1]) ? 1 : 0);
        @(negedge clk);
        phase = 4'h0;
        sel   = 1'b0;
        if (mode35) apply_cmd(c);
    endtask

    task automatic idle(input int n);
        phase = 4'h0;
        sel   = 1'b0;
        q6    = 1'b0;
        q7    = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // Read every status code and compare with the model (R9).
    task automatic sweep_status(input string tag);
        int v;
        for (int c = 0; c < 16; c++) begin
            read_stat(c, v);
            check(tag, v, exp_stat(c));
            @(negedge clk);
            if (c[0] && c[2]) begin
                m_motor = 0;
                m_dir   = 0;
                m_eject = 0;
            end
        end
        idle(1);
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        int v;
        rst_n        = 1'b0;
        mode35       = 1'b1;
        sel          = 1'b0;
        phase        = 4'h0;
        q6           = 1'b0;
        q7           = 1'b0;
        media_insert = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R14 reset state
        check("R14 head_pos", head_pos, 0);
        check("R14 motor35", motor35, 0);
        check("R14 arm_pos", arm_pos, 0);
        check("R14 ctl_reset", ctl_reset, 0);
        check("R14 enable2", enable2, 0);
        sweep_status("R14 R9 status after reset");

        // R9 gating by q7/q6 and mode
        read_stat(9, v);
        q7 = 1'b1;
        #1;
        check("R9 q7=1 gives 0", status_bit, 0);
        q7 = 1'b0;
        q6 = 1'b0;
        #1;
        check("R9 q6=0 gives 0", status_bit, 0);
        q6 = 1'b1;
        mode35 = 1'b0;
        #1;
        check("R9 mode35=0 gives 0", status_bit, 0);
        mode35 = 1'b1;
        #1;
        check("R9 present bit", status_bit, 1);
        idle(1);

        // R4 step inward past the top, then outward past the bottom
        issue(0);
        for (int k = 0; k < TRACKS + 5; k++) begin
            issue(2);
            check("R4 R2 step inward", head_pos, m_track * 2 + m_side);
        end
        check("R4 saturate at top", head_pos, (TRACKS - 1) * 2);
        issue(1);
        for (int k = 0; k < TRACKS + 5; k++) begin
            issue(2);
            check("R4 step outward", head_pos, m_track * 2 + m_side);
        end
        check("R4 saturate at 0", head_pos, 0);

        // R7 step-complete timing for a saturated step
        issue(2);
        for (int i = 0; i < STEP_CYC + 3; i++) begin
            read_stat(1, v);
            check("R7 step complete timing", v, (i >= STEP_CYC) ? 1 : 0);
            @(negedge clk);
        end
        idle(1);

        // R5 side and head position encoding
        issue(9);
        check("R5 side 1 at track 0", head_pos, 1);
        issue(0);
        repeat (3) issue(2);
        check("R5 track 3 side 1", head_pos, 7);
        issue(8);
        check("R5 side 0", head_pos, 6);
        issue(9);
        check("R5 side 1 again", head_pos, 7);

        // R6 motor spin-up timing
        issue(3);
        check("R6 motor35 on", motor35, 1);
        for (int i = 0; i < SPINUP_CYC + 3; i++) begin
            read_stat(3, v);
            check("R6 at speed timing", v, (i >= SPINUP_CYC) ? 1 : 0);
            @(negedge clk);
        end
        idle(1);
        issue(3);
        read_stat(3, v);
        check("R6 re-on keeps speed", v, 1);
        idle(1);
        issue(4);
        check("R6 motor35 off", motor35, 0);
        read_stat(3, v);
        check("R6 at speed cleared", v, 0);
        idle(1);

        // R3 phase 3 held high steps only once
        @(negedge clk);
        phase = 4'b0010;
        @(negedge clk);
        phase[3] = 1'b1;
        repeat (5) @(negedge clk);
        phase = 4'h0;
        apply_cmd(2);
        @(negedge clk);
        check("R3 held phase 3 single step", head_pos, m_track * 2 + m_side);
        check("R3 track is 4", head_pos, 9);

        // R8 eject and insertion
        issue(6);
        read_stat(6, v);
        check("R8 ejected set", v, 1);
        read_stat(9, v);
        check("R8 present clear", v, 0);
        idle(1);
        media_insert = 1'b1;
        @(negedge clk);
        media_insert = 1'b0;
        m_eject = 0;
        read_stat(6, v);
        check("R8 insert clears eject", v, 0);
        idle(1);

        // R13 unassigned codes change nothing
        issue(10);
        issue(11);
        issue(12);
        issue(14);
        check("R13 head unchanged", head_pos, m_track * 2 + m_side);
        idle(STEP_CYC + 2);
        sweep_status("R13 R9 status after unassigned codes");

        // R9 sweep in a busy state (codes 5,7,13,15 reset as modelled)
        issue(3);
        issue(6);
        issue(0);
        idle(SPINUP_CYC + 2);
        sweep_status("R9 status sweep busy state");

        // R10 reset combination with a phase-3 rise
        issue(3);
        issue(6);
        issue(0);
        idle(2);
        phase = 4'b1101;
        #1;
        check("R10 ctl_reset high", ctl_reset, 1);
        check("R11 enable2 low without phase 1", enable2, 0);
        @(negedge clk);
        phase = 4'h0;
        m_motor = 0;
        m_dir   = 0;
        m_eject = 0;
        check("R10 motor cleared", motor35, 0);
        check("R10 head unchanged", head_pos, m_track * 2 + m_side);
        read_stat(0, v);
        check("R10 direction cleared", v, 0);
        read_stat(6, v);
        check("R10 eject cleared", v, 0);
        idle(1);
        check("R1 arm unmoved in 3.5 mode", arm_pos, 0);

        // R1 R12 5.25-inch arm stepping
        mode35 = 1'b0;
        phase  = 4'b0101;
        #1;
        check("R1 no reset combo in 5.25 mode", ctl_reset, 0);
        phase = 4'b1010;
        #1;
        check("R1 R11 no enable2 in 5.25 mode", enable2, 0);
        @(negedge clk);
        check("R12 two phases do not move", arm_pos, m_arm);
        for (int k = 0; k < ARM_STEPS + 3; k++) begin
            phase = 4'(1 << ((m_arm + 1) % 4));
            @(negedge clk);
            if (m_arm < ARM_STEPS - 1) m_arm++;
            check("R12 arm up", arm_pos, m_arm);
            check("R1 head frozen in 5.25 mode", head_pos, m_track * 2 + m_side);
        end
        phase = 4'(1 << ((m_arm + 2) % 4));
        @(negedge clk);
        check("R12 opposite phase holds", arm_pos, m_arm);
        for (int k = 0; k < ARM_STEPS + 3; k++) begin
            phase = 4'(1 << ((m_arm + 3) % 4));
            @(negedge clk);
            if (m_arm > 0) m_arm--;
            check("R12 arm down", arm_pos, m_arm);
        end
        idle(1);
        issue(3);
        check("R1 no motor command in 5.25 mode", motor35, 0);
        check("R1 arm unmoved by command phases", arm_pos, m_arm);
        mode35 = 1'b1;
        @(negedge clk);
        read_stat(2, v);
        check("R1 motor status after mode return", v, 0);
        idle(1);

        done = 1'b1;
        report();
    end

endmodule